// File: doc/BRIEF.md
# Serial Cassette Host Packet Sequencer

This block is the host side of a byte-oriented packet protocol that talks to a serial cassette drive. It sends and receives bytes over a UART-like channel. It wakes the drive with a line break and a pair of INIT flags. It then turns a single block read or write request into a command packet. For writes it streams data packets, and each one waits for a CONTINUE byte from the drive. For reads it collects data packets into a byte buffer. A request finishes with an END status packet, or with an abort.

Checksums are computed outside the block, by a unit that takes a clear strobe, a byte-enable strobe and the byte. It returns a 16-bit running sum whose new value is visible from the cycle after each fed byte. The block streams packet bytes into that unit. It sends the sum as the last two bytes of each packet it transmits, and it compares the sum against the two trailing bytes of each packet it receives. Request data lives in an external buffer addressed by byte offset from the start of the request.

Top module: `tape_link_seq`

## Requirements
- R1: After reset the block asserts `tx_break` while it sends four 0x00 bytes. It then sends two INIT bytes (0x04) with break removed. `busy` is low out of reset.
- R2: After the INIT bytes, a received CONTINUE (0x10) makes the link idle, with no further transmission. Any other byte repeats the whole break-and-INIT sequence.
- R3: An accepted request sends a 14-byte command packet, least significant byte first, in this order: flag 0x02, count 10, opcode (read 0x02, write 0x03), modifier, unit, switches 0, 16-bit sequence 0, 16-bit byte count, 16-bit block number, and 16-bit checksum.
- R4: The modifier is 0x01 for a write with verify requested, and 0 otherwise. Verify is ignored for reads.
- R5: Every packet the block transmits starts its checksum run with `ck_clr` on its first byte and feeds every byte except the final two. The final two bytes are `ck_sum`, low byte first.
- R6: For a write, each data packet waits for a CONTINUE byte. It then goes out as DATA flag 0x01, a count n = min(128, remaining), n buffer bytes at ascending offsets from 0, and a 2-byte checksum.
- R7: After the last data packet the block transmits nothing more and keeps `busy` high until the END packet arrives.
- R8: For a read, each received packet is a flag, a count, that many body bytes and 2 checksum bytes. The body of a DATA (0x01) packet goes into the buffer at ascending offsets, and reception then continues with the next header.
- R9: A received packet with flag 0x02 and opcode (first body byte) 0x40 ends the request. `done` pulses and `busy` falls. `err` pulses with `done` when the modifier (second body byte) is above 1. A modifier of exactly 1 increments `soft_cnt`.
- R10: A received checksum that differs from `ck_sum` increments `cks_cnt`. The packet is still processed by its flag.
- R11: An INIT byte in a flag position, received while waiting for CONTINUE or for a packet header, aborts the request. `done` and `err` pulse, `busy` falls, and the break-and-INIT sequence restarts.
- R12: A receive error (`rx_err`), outside idle, increments `soft_cnt` and restarts the break-and-INIT sequence. The pending request is kept and its command packet is sent again after the link comes up.
- R13: A request strobe while `busy` is high is ignored. The transfer in progress keeps its direction, and no second command follows its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_verify | input | 1 | Ask for write with read-back verify |
| req_unit | input | 8 | Drive unit number |
| req_block | input | 16 | Starting block number |
| req_count | input | 16 | Byte count of the transfer |
| busy | output | 1 | A request is pending or in progress |
| done | output | 1 | One-cycle pulse at request completion or abort |
| err | output | 1 | One-cycle pulse with `done` on hard error or abort |
| tx_valid | output | 1 | Transmit byte offered |
| tx_break | output | 1 | Hold the line in break |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte on this edge |
| rx_valid | input | 1 | Received byte valid for one cycle |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Overrun or break seen by the receiver |
| ck_clr | output | 1 | Start a new checksum run with this byte |
| ck_en | output | 1 | Feed `ck_byte` into the checksum |
| ck_byte | output | 8 | Byte for the checksum unit |
| ck_sum | input | 16 | Running checksum |
| mem_addr | output | 16 | Buffer byte offset |
| mem_we | output | 1 | Write a received data byte |
| mem_wdata | output | 8 | Received data byte |
| mem_rdata | input | 8 | Buffer byte at `mem_addr` |
| soft_cnt | output | 8 | Soft error count |
| cks_cnt | output | 8 | Checksum error count |

## Verification
A transmitted byte counts as sent on the rising edge where `tx_valid` and `tx_ready` are both high. The bench records each such byte at the preceding falling edge and compares whole packets once all their bytes have been collected. `done`, `err` and the counters change on the edge that takes the second checksum byte of the END packet, or the offending byte for aborts and receive errors. The bench counts those pulses at falling edges and compares deltas a few cycles later. For the silence after the last write packet and after completion, the bench watches the transmit stream for 20 cycles.

// File: rtl/tape_link_seq.sv
module tape_link_seq #(
  parameter int CHUNK = 128,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_write,
  input  logic          req_verify,
  input  logic [7:0]    req_unit,
  input  logic [15:0]   req_block,
  input  logic [15:0]   req_count,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          tx_valid,
  output logic          tx_break,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_err,
  output logic          ck_clr,
  output logic          ck_en,
  output logic [7:0]    ck_byte,
  input  logic [15:0]   ck_sum,
  output logic [15:0]   mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [CW-1:0] soft_cnt,
  output logic [CW-1:0] cks_cnt
);
  localparam logic [7:0] F_DATA = 8'h01, F_CMD = 8'h02, F_INIT = 8'h04, F_CONT = 8'h10;
  localparam logic [7:0] OP_RD = 8'h02, OP_WR = 8'h03, OP_END = 8'h40;
  localparam logic [7:0] CMD_LAST = 8'd13;
  localparam logic [7:0] CK_FIRST = 8'd12;

  typedef enum logic [3:0] {
    S_BRK, S_INI, S_INW, S_IDLE, S_CMD, S_WAITC,
    S_TXH, S_TXD, S_TXC, S_RXH, S_RXB, S_RXC
  } st_t;

  st_t st;
  logic [7:0]  idx, n, unit, rflag, rcnt, rop, rmod, clo;
  logic [15:0] blk, cnt, rem, off;
  logic        pend, wr, ver, done_q, err_q;
  logic [CW-1:0] soft_q, cks_q;
  logic [7:0]  cmdb, chunk;
  logic        txgo, rxok, rxst;

  assign busy     = pend;
  assign done     = done_q;
  assign err      = err_q;
  assign soft_cnt = soft_q;
  assign cks_cnt  = cks_q;
  assign tx_break = (st == S_BRK);
  assign txgo     = tx_valid && tx_ready;
  assign rxok     = rx_valid && !rx_err;
  assign rxst     = (st == S_WAITC) || (st == S_RXH) || (st == S_RXB);
  assign chunk    = (rem > 16'(CHUNK)) ? 8'(CHUNK) : rem[7:0];

  always_comb begin
    case (idx)
      8'd0:  cmdb = F_CMD;
      8'd1:  cmdb = 8'd10;
      8'd2:  cmdb = wr ? OP_WR : OP_RD;
      8'd3:  cmdb = (wr && ver) ? 8'h01 : 8'h00;
      8'd4:  cmdb = unit;
      8'd8:  cmdb = cnt[7:0];
      8'd9:  cmdb = cnt[15:8];
      8'd10: cmdb = blk[7:0];
      8'd11: cmdb = blk[15:8];
      8'd12: cmdb = ck_sum[7:0];
      8'd13: cmdb = ck_sum[15:8];
      default: cmdb = 8'h00;
    endcase
  end

  always_comb begin
    tx_valid = 1'b1;
    case (st)
      S_BRK:   tx_data = 8'h00;
      S_INI:   tx_data = F_INIT;
      S_CMD:   tx_data = cmdb;
      S_TXH:   tx_data = (idx == 8'd0) ? F_DATA : n;
      S_TXD:   tx_data = mem_rdata;
      S_TXC:   tx_data = (idx == 8'd0) ? ck_sum[7:0] : ck_sum[15:8];
      default: begin tx_valid = 1'b0; tx_data = 8'h00; end
    endcase
  end

  assign ck_en  = (txgo && ((st == S_CMD) ? (idx < CK_FIRST) : (st == S_TXH || st == S_TXD)))
               || (rxok && rxst);
  assign ck_clr = (txgo && idx == 8'd0 && (st == S_CMD || st == S_TXH))
               || (rxok && (st == S_WAITC || (st == S_RXH && idx == 8'd0)));
  assign ck_byte   = rxst ? rx_data : tx_data;
  assign mem_addr  = off;
  assign mem_we    = rxok && st == S_RXB && rflag == F_DATA;
  assign mem_wdata = rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_BRK; idx <= '0; n <= '0; unit <= '0; rflag <= '0; rcnt <= '0;
      rop <= '0; rmod <= '0; clo <= '0; blk <= '0; cnt <= '0; rem <= '0; off <= '0;
      pend <= 1'b0; wr <= 1'b0; ver <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      soft_q <= '0; cks_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (req && !pend) begin
        pend <= 1'b1; wr <= req_write; ver <= req_verify;
        unit <= req_unit; blk <= req_block; cnt <= req_count;
      end
      if (rx_err && st != S_IDLE) begin
        soft_q <= soft_q + 1'b1;
        st <= S_BRK; idx <= '0;
      end else begin
        case (st)
          S_BRK: if (txgo) begin
            if (idx == 8'd3) begin st <= S_INI; idx <= '0; end
            else idx <= idx + 8'd1;
          end
          S_INI: if (txgo) begin
            if (idx == 8'd1) begin st <= S_INW; idx <= '0; end
            else idx <= idx + 8'd1;
          end
          S_INW: if (rxok) st <= (rx_data == F_CONT) ? S_IDLE : S_BRK;
          S_IDLE: if (pend) begin
            st <= S_CMD; idx <= '0; off <= '0; rem <= cnt;
          end
          S_CMD: if (txgo) begin
            if (idx == CMD_LAST) begin st <= wr ? S_WAITC : S_RXH; idx <= '0; end
            else idx <= idx + 8'd1;
          end
          S_WAITC: if (rxok) begin
            if (rx_data == F_CONT) begin
              st <= S_TXH; idx <= '0; n <= chunk;
            end else if (rx_data == F_CMD) begin
              st <= S_RXH; idx <= 8'd1; rflag <= rx_data;
            end else begin
              pend <= 1'b0; done_q <= 1'b1; err_q <= 1'b1; st <= S_BRK; idx <= '0;
            end
          end
          S_TXH: if (txgo) begin
            if (idx == 8'd0) idx <= 8'd1;
            else begin st <= (n == 8'd0) ? S_TXC : S_TXD; idx <= '0; end
          end
          S_TXD: if (txgo) begin
            off <= off + 16'd1;
            if (idx == n - 8'd1) begin st <= S_TXC; idx <= '0; end
            else idx <= idx + 8'd1;
          end
          S_TXC: if (txgo) begin
            if (idx == 8'd0) idx <= 8'd1;
            else begin
              rem <= rem - {8'd0, n};
              st  <= (rem != {8'd0, n}) ? S_WAITC : S_RXH;
              idx <= '0;
            end
          end
          S_RXH: if (rxok) begin
            if (idx == 8'd0) begin
              if (rx_data == F_INIT) begin
                pend <= 1'b0; done_q <= 1'b1; err_q <= 1'b1; st <= S_BRK;
              end else begin
                rflag <= rx_data; idx <= 8'd1;
              end
            end else begin
              rcnt <= rx_data; idx <= '0;
              st <= (rx_data == 8'd0) ? S_RXC : S_RXB;
            end
          end
          S_RXB: if (rxok) begin
            if (rflag == F_DATA) off <= off + 16'd1;
            if (idx == 8'd0) rop <= rx_data;
            if (idx == 8'd1) rmod <= rx_data;
            if (idx == rcnt - 8'd1) begin st <= S_RXC; idx <= '0; end
            else idx <= idx + 8'd1;
          end
          S_RXC: if (rxok) begin
            if (idx == 8'd0) begin clo <= rx_data; idx <= 8'd1; end
            else begin
              idx <= '0;
              if ({rx_data, clo} != ck_sum) cks_q <= cks_q + 1'b1;
              if (rflag == F_DATA) st <= S_RXH;
              else if (rflag == F_CMD && rop == OP_END) begin
                st <= S_IDLE; pend <= 1'b0; done_q <= 1'b1;
                err_q <= (rmod > 8'd1);
                if (rmod == 8'd1) soft_q <= soft_q + 1'b1;
              end else begin
                soft_q <= soft_q + 1'b1; st <= S_BRK;
              end
            end
          end
          default: st <= S_BRK;
        endcase
      end
    end
  end

  a_r9_busy_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r13_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
  a_r11_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r5_clear_feeds_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ck_clr |-> ck_en);
  a_r8_store_while_silent: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !tx_valid);
  a_r7_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !rx_err) |=> tx_valid);
  a_r12_soft_step: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_cnt == $past(soft_cnt)) || (soft_cnt == $past(soft_cnt) + 1'b1));
endmodule

// File: tb/tape_link_seq_tb.sv
module tape_link_seq_tb;
  localparam int TCK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_write = 1'b0, req_verify = 1'b0;
  logic [7:0] req_unit = 8'd1;
  logic [15:0] req_block = '0, req_count = '0;
  logic busy, done, err, tx_valid, tx_break, tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic rx_valid = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic ck_clr, ck_en;
  logic [7:0] ck_byte;
  logic [15:0] ck_sum, ck_acc = '0;
  logic ck_par = 1'b0;
  logic [15:0] mem_addr;
  logic mem_we;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] soft_cnt, cks_cnt;

  logic [7:0] mem [0:511];
  logic [7:0] pkt [0:299];
  logic [8:0] txq [$];
  int checks = 0, errors = 0, done_n = 0, err_n = 0;

  // {write, verify, count, block, end modifier}
  localparam logic [41:0] VEC [4] = '{
    {1'b1, 1'b0, 16'd5,   16'd7,   8'd0},
    {1'b1, 1'b1, 16'd200, 16'd300, 8'd1},
    {1'b0, 1'b0, 16'd3,   16'd1,   8'd0},
    {1'b0, 1'b1, 16'd130, 16'd511, 8'd3}
  };

  tape_link_seq u_dut (
    .clk, .rst_n, .req, .req_write, .req_verify, .req_unit, .req_block, .req_count,
    .busy, .done, .err, .tx_valid, .tx_break, .tx_data, .tx_ready,
    .rx_valid, .rx_data, .rx_err, .ck_clr, .ck_en, .ck_byte, .ck_sum,
    .mem_addr, .mem_we, .mem_wdata, .mem_rdata, .soft_cnt, .cks_cnt
  );

  always #(TCK/2) clk = ~clk;
  assign ck_sum = ck_acc;
  assign mem_rdata = mem[mem_addr[8:0]];

  function automatic logic [15:0] add16(input logic [15:0] s, input logic [15:0] v);
    logic [16:0] t;
    t = {1'b0, s} + {1'b0, v};
    return t[15:0] + {15'd0, t[16]};
  endfunction

  function automatic logic [15:0] csum_of(input int n);
    logic [15:0] s = '0;
    for (int i = 0; i < n; i++)
      s = add16(s, (i % 2) ? {pkt[i], 8'h00} : {8'h00, pkt[i]});
    return s;
  endfunction

  // external checksum unit model and port monitors
  always @(negedge clk) begin
    if (!rst_n) begin
      ck_acc = '0; ck_par = 1'b0;
    end else begin
      if (ck_en) begin
        logic [15:0] s;
        logic p;
        s = ck_clr ? 16'd0 : ck_acc;
        p = ck_clr ? 1'b0 : ck_par;
        ck_acc = add16(s, p ? {ck_byte, 8'h00} : {8'h00, ck_byte});
        ck_par = !p;
      end
      if (tx_valid && tx_ready) txq.push_back({tx_break, tx_data});
      if (mem_we) mem[mem_addr[8:0]] = mem_wdata;
      if (done) done_n++;
      if (err) err_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pop_tx(output logic [8:0] v);
    while (txq.size() == 0) @(negedge clk);
    v = txq.pop_front();
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic pulse_rx_err;
    @(posedge clk); #1;
    rx_err = 1'b1;
    @(posedge clk); #1;
    rx_err = 1'b0;
  endtask

  task automatic expect_init(input string tag);
    logic [8:0] v;
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      pop_tx(v);
      if (v != ((i < 4) ? 9'h100 : 9'h004)) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic start_req(input bit w, input bit vf, input int cnt, input int blk);
    @(posedge clk); #1;
    req = 1'b1; req_write = w; req_verify = vf;
    req_count = 16'(cnt); req_block = 16'(blk);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic check_cmd(input bit w, input bit vf, input int cnt, input int blk);
    logic [8:0] v;
    logic [15:0] s;
    for (int i = 0; i < 14; i++) begin pop_tx(v); pkt[i] = v[7:0]; end
    chk(pkt[0] == 8'h02 && pkt[1] == 8'd10, "R3 flag/count", {pkt[0], pkt[1]}, 16'h020a);
    chk(pkt[2] == (w ? 8'h03 : 8'h02), "R3 opcode", pkt[2], w ? 3 : 2);
    chk(pkt[3] == ((w && vf) ? 8'h01 : 8'h00), "R4 modifier", pkt[3], (w && vf) ? 1 : 0);
    chk(pkt[4] == 8'd1 && pkt[5] == 0 && pkt[6] == 0 && pkt[7] == 0, "R3 unit/sw/seq",
        pkt[4], 1);
    chk({pkt[9], pkt[8]} == 16'(cnt), "R3 byte count", {pkt[9], pkt[8]}, cnt);
    chk({pkt[11], pkt[10]} == 16'(blk), "R3 block", {pkt[11], pkt[10]}, blk);
    s = csum_of(12);
    chk({pkt[13], pkt[12]} == s, "R5 command checksum", {pkt[13], pkt[12]}, s);
  endtask

  task automatic send_packet(input logic [7:0] flag, input int n, input bit bad);
    logic [15:0] s;
    pkt[0] = flag; pkt[1] = 8'(n);
    s = csum_of(n + 2) ^ (bad ? 16'h0001 : 16'h0000);
    for (int i = 0; i < n + 2; i++) send_rx(pkt[i]);
    send_rx(s[7:0]); send_rx(s[15:8]);
  endtask

  task automatic send_end(input logic [7:0] md, input int cnt, input int blk);
    pkt[2] = 8'h40; pkt[3] = md; pkt[4] = 8'd1; pkt[5] = 0; pkt[6] = 0; pkt[7] = 0;
    pkt[8] = 8'(cnt); pkt[9] = 8'(cnt >> 8); pkt[10] = 8'(blk); pkt[11] = 8'(blk >> 8);
    send_packet(8'h02, 10, 1'b0);
  endtask

  task automatic write_packets(input int cnt);
    logic [8:0] v;
    logic [15:0] s;
    int rem = cnt, off = 0, n, bad;
    while (rem > 0) begin
      send_rx(8'h10);
      n = (rem > 128) ? 128 : rem;
      pop_tx(v); pkt[0] = v[7:0];
      pop_tx(v); pkt[1] = v[7:0];
      chk(pkt[0] == 8'h01 && pkt[1] == 8'(n), "R6 data header", pkt[1], n);
      bad = 0;
      for (int i = 0; i < n; i++) begin
        pop_tx(v); pkt[2 + i] = v[7:0];
        if (v[7:0] != mem[off + i]) bad++;
      end
      chk(bad == 0, "R6 data bytes", bad, 0);
      s = csum_of(n + 2);
      pop_tx(v); pkt[n + 2] = v[7:0];
      pop_tx(v); pkt[n + 3] = v[7:0];
      chk({pkt[n + 3], pkt[n + 2]} == s, "R5 data checksum", {pkt[n + 3], pkt[n + 2]}, s);
      rem -= n; off += n;
    end
    repeat (20) @(negedge clk);
    chk(txq.size() == 0 && busy, "R7 silent while awaiting end", txq.size(), 0);
  endtask

  task automatic read_packets(input int cnt, input int blk, input bit bad);
    int rem = cnt, off = 0, n;
    while (rem > 0) begin
      n = (rem > 128) ? 128 : rem;
      for (int i = 0; i < n; i++) pkt[2 + i] = 8'((off + i) * 3 + blk);
      send_packet(8'h01, n, bad);
      rem -= n; off += n;
    end
  endtask

  task automatic check_read_mem(input int cnt, input int blk, input string tag);
    int bad = 0;
    for (int i = 0; i < cnt; i++) if (mem[i] != 8'(i * 3 + blk)) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0, e0, s0, c0;
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && soft_cnt == 0 && cks_cnt == 0 && tx_break, "R1 reset state",
        busy, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    expect_init("R1 break nulls then INIT");
    send_rx(8'h33);
    expect_init("R2 non-continue repeats init");
    send_rx(8'h10);
    repeat (10) @(negedge clk);
    chk(txq.size() == 0 && !busy, "R2 idle after continue", txq.size(), 0);

    for (int k = 0; k < 4; k++) begin
      logic w, vf;
      int cnt, blk, md;
      {w, vf} = VEC[k][41:40];
      cnt = int'(VEC[k][39:24]); blk = int'(VEC[k][23:8]); md = int'(VEC[k][7:0]);
      d0 = done_n; e0 = err_n; s0 = soft_cnt;
      if (w) for (int i = 0; i < cnt; i++) mem[i] = 8'(i * 7 + blk);
      else   for (int i = 0; i < cnt; i++) mem[i] = 8'h00;
      start_req(w, vf, cnt, blk);
      chk(busy, "R13 busy after request", busy, 1);
      check_cmd(w, vf, cnt, blk);
      if (w) write_packets(cnt);
      else   read_packets(cnt, blk, 1'b0);
      send_end(8'(md), cnt, blk);
      repeat (3) @(negedge clk);
      chk(done_n == d0 + 1 && !busy, "R9 done and busy low", done_n - d0, 1);
      chk(err_n == e0 + ((md > 1) ? 1 : 0), "R9 hard error", err_n - e0, (md > 1) ? 1 : 0);
      chk(int'(soft_cnt) == s0 + ((md == 1) ? 1 : 0), "R9 soft error", soft_cnt,
          s0 + ((md == 1) ? 1 : 0));
      if (!w) check_read_mem(cnt, blk, "R8 read data stored");
    end

    // R10 checksum mismatch still handled
    d0 = done_n; c0 = cks_cnt;
    for (int i = 0; i < 4; i++) mem[i] = 8'h00;
    start_req(1'b0, 1'b0, 4, 9);
    check_cmd(1'b0, 1'b0, 4, 9);
    read_packets(4, 9, 1'b1);
    send_end(8'd0, 4, 9);
    repeat (3) @(negedge clk);
    chk(int'(cks_cnt) == c0 + 1, "R10 checksum error count", cks_cnt, c0 + 1);
    check_read_mem(4, 9, "R10 data kept");
    chk(done_n == d0 + 1 && !busy, "R10 completes", done_n - d0, 1);

    // R11 unexpected INIT while waiting for continue
    d0 = done_n; e0 = err_n;
    start_req(1'b1, 1'b0, 4, 3);
    check_cmd(1'b1, 1'b0, 4, 3);
    send_rx(8'h04);
    repeat (3) @(negedge clk);
    chk(done_n == d0 + 1 && err_n == e0 + 1 && !busy, "R11 abort", err_n - e0, 1);
    expect_init("R11 reinit after abort");
    send_rx(8'h10);

    // R11 unexpected INIT in a read header flag position
    d0 = done_n; e0 = err_n;
    start_req(1'b0, 1'b0, 2, 4);
    check_cmd(1'b0, 1'b0, 2, 4);
    send_rx(8'h04);
    repeat (3) @(negedge clk);
    chk(done_n == d0 + 1 && err_n == e0 + 1 && !busy, "R11 abort on header", err_n - e0, 1);
    expect_init("R11 reinit after header abort");
    send_rx(8'h10);

    // R12 receive error restarts and retries
    d0 = done_n; s0 = soft_cnt;
    for (int i = 0; i < 2; i++) mem[i] = 8'h00;
    start_req(1'b0, 1'b0, 2, 5);
    check_cmd(1'b0, 1'b0, 2, 5);
    pulse_rx_err();
    repeat (2) @(negedge clk);
    chk(int'(soft_cnt) == s0 + 1 && busy, "R12 soft count and still busy", soft_cnt, s0 + 1);
    expect_init("R12 reinit after rx error");
    send_rx(8'h10);
    check_cmd(1'b0, 1'b0, 2, 5);
    read_packets(2, 5, 1'b0);
    send_end(8'd0, 2, 5);
    repeat (3) @(negedge clk);
    chk(done_n == d0 + 1 && !busy, "R12 retried request completes", done_n - d0, 1);
    check_read_mem(2, 5, "R12 retried data");

    // R13 request while busy is ignored
    d0 = done_n;
    for (int i = 0; i < 3; i++) mem[i] = 8'(i * 7 + 2);
    start_req(1'b1, 1'b0, 3, 2);
    check_cmd(1'b1, 1'b0, 3, 2);
    start_req(1'b0, 1'b0, 9, 99);
    write_packets(3);
    send_end(8'd0, 3, 2);
    repeat (20) @(negedge clk);
    chk(done_n == d0 + 1 && !busy && txq.size() == 0, "R13 no second command",
        txq.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule